// File: doc/BRIEF.md
# Host Cold/Warm Reset Pulser

This block produces the two host reset styles that a power controller has to offer. A cold reset pulls the system power-good indication low for a fixed interval and then lets it return, so that the platform controller tears power down and brings it back. A warm reset asserts a reset line that is shared with other drivers, for a shorter interval. That line is driven the open-drain way: the block never drives it high. It only switches a low-driving output on or off. A warm reset reinitialises the processor and does not touch power-good.

A sequencer presents its own power-good value on `pg_in_i`. The block forwards that value to `pg_out_o` unchanged except while a cold pulse is running. A request is a strobe on `req_i`, sampled on a rising clock edge, and `cold_sel_i` chooses the reset style. A cold request that arrives while power-good is already low does nothing, because power is already down. While a pulse is in progress `busy_o` is high and every new request is discarded. Each pulse width is a parameter in microseconds, and the block turns it into clock cycles through a clocks-per-microsecond parameter. The defaults are 100 µs for cold, which covers a minimum of roughly 91 µs, and 10 µs for warm, which covers a minimum of roughly 500 ns.

Top module: `host_reset_pulser`

## Requirements
- R1: During reset and in the first cycle after it, `busy_o` and `rst_oe_o` are 0 and `pg_out_o` equals `pg_in_i`.
- R2: While idle (`busy_o` = 0), `pg_out_o` equals `pg_in_i` in every cycle.
- R3: Suppose a request is sampled while idle with `cold_sel_i` = 1 and `pg_in_i` = 1. Then `pg_out_o` is 0 for exactly COLD_US*CLKS_PER_US cycles, beginning in the cycle after that edge, and afterwards follows `pg_in_i` again.
- R4: A cold request sampled while `pg_in_i` = 0 is ignored. `busy_o` stays 0, `rst_oe_o` stays 0 and `pg_out_o` keeps following `pg_in_i`.
- R5: Suppose a request is sampled while idle with `cold_sel_i` = 0. Then `rst_oe_o` = 1 (1 means drive the line low) for exactly WARM_US*CLKS_PER_US cycles, beginning in the cycle after that edge.
- R6: During a warm pulse, `pg_out_o` equals `pg_in_i`.
- R7: During a cold pulse, `rst_oe_o` stays 0.
- R8: `busy_o` is 1 in exactly the cycles in which a pulse is active, and 0 otherwise.
- R9: A request sampled while `busy_o` = 1 is dropped, and this includes the final cycle of a pulse. A request sampled in the first idle cycle afterwards is accepted.
- R10: During a cold pulse, `pg_out_o` stays 0 even if `pg_in_i` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Reset request strobe |
| cold_sel_i | input | 1 | 1 selects cold reset, 0 selects warm reset |
| pg_in_i | input | 1 | Power-good value coming from the sequencer |
| pg_out_o | output | 1 | Power-good value sent to the platform controller |
| rst_oe_o | output | 1 | Output enable that drives the reset line low |
| busy_o | output | 1 | A pulse is in progress |

## Verification
Two events can fall in the same cycle: the expiry of a running pulse and the arrival of a new request. The bench holds `req_i` high without a break across a whole warm pulse. A behavioural model then judges each edge. It expects the request present in the final busy cycle to be discarded, and the one in the very next idle cycle to start a fresh pulse. A second case of overlap is a cold request that lands on a cycle where `pg_in_i` is low, and the bench provokes it directly. It also toggles `pg_in_i` in the middle of both pulse types to show that a cold pulse masks it and a warm pulse passes it through.

// File: rtl/hrp_pkg.sv
// Shared types for the host reset pulser.
// Assumes: nothing beyond a single clock domain.
package hrp_pkg;
    // Which pulse, if any, is currently running
    typedef enum logic [1:0] {
        HRP_IDLE = 2'd0,
        HRP_COLD = 2'd1,
        HRP_WARM = 2'd2
    } hrp_mode_e;
endpackage

// File: rtl/hrp_req_decode.sv
// Request decoder: turns a request strobe into a start of a cold or a warm pulse.
// Assumes: busy comes from the pulse state register of the same clock domain.
module hrp_req_decode (
    input  logic req_i,
    input  logic cold_sel_i,
    input  logic pg_in_i,
    input  logic busy_i,
    output logic start_cold_o,
    output logic start_warm_o
);
    // Accept only when idle; a cold start also needs power-good to be high
    always_comb begin
        start_cold_o = req_i && !busy_i && cold_sel_i && pg_in_i;
        start_warm_o = req_i && !busy_i && !cold_sel_i;
    end
endmodule

// File: rtl/hrp_pulse_timer.sv
// Down-counting pulse timer. After load, active stays high for load_val+1 cycles.
// Assumes: load is not asserted while active (the decoder guarantees this).
module hrp_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             active_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    // Load, count down, then drop active after the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            cnt_q    <= load_val_i;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Last active cycle flag
    always_comb begin
        active_o = active_q;
        expire_o = active_q && (cnt_q == '0);
    end
endmodule

// File: rtl/hrp_out_stage.sv
// Output stage: forms the power-good override and the open-drain enable from the mode.
// Assumes: the line is pulled up elsewhere; rst_oe_o = 1 means drive low.
module hrp_out_stage
    import hrp_pkg::*;
(
    input  hrp_mode_e mode_i,
    input  logic      pg_in_i,
    output logic      pg_out_o,
    output logic      rst_oe_o
);
    // Hold power-good low during a cold pulse; enable the low driver during a warm pulse
    always_comb begin
        pg_out_o = (mode_i == HRP_COLD) ? 1'b0 : pg_in_i;
        rst_oe_o = (mode_i == HRP_WARM);
    end
endmodule

// File: rtl/host_reset_pulser.sv
// Host reset pulser top. Generates a timed power-good drop (cold) or an
// open-drain reset pulse (warm) on request.
// Assumes: req_i, cold_sel_i and pg_in_i are synchronous to clk.
module host_reset_pulser
    import hrp_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int COLD_US     = 100,
    parameter int WARM_US     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic cold_sel_i,
    input  logic pg_in_i,
    output logic pg_out_o,
    output logic rst_oe_o,
    output logic busy_o
);
    localparam int COLD_CYC = CLKS_PER_US * COLD_US;
    localparam int WARM_CYC = CLKS_PER_US * WARM_US;
    localparam int MAX_CYC  = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
    localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    hrp_mode_e        mode_q;
    logic             start_cold;
    logic             start_warm;
    logic             tmr_active;
    logic             tmr_expire;
    logic [CNT_W-1:0] load_val;

    hrp_req_decode u_dec (
        .req_i        (req_i),
        .cold_sel_i   (cold_sel_i),
        .pg_in_i      (pg_in_i),
        .busy_i       (busy_o),
        .start_cold_o (start_cold),
        .start_warm_o (start_warm)
    );

    // Select the pulse length in cycles for the style being started
    always_comb begin
        load_val = start_cold ? CNT_W'(COLD_CYC - 1) : CNT_W'(WARM_CYC - 1);
    end

    hrp_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_cold || start_warm),
        .load_val_i (load_val),
        .active_o   (tmr_active),
        .expire_o   (tmr_expire)
    );

    // Track which pulse is running; return to idle when the timer expires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= HRP_IDLE;
        end else if (start_cold) begin
            mode_q <= HRP_COLD;
        end else if (start_warm) begin
            mode_q <= HRP_WARM;
        end else if (tmr_expire) begin
            mode_q <= HRP_IDLE;
        end
    end

    // Busy while a pulse is in progress
    always_comb begin
        busy_o = (mode_q != HRP_IDLE);
    end

    hrp_out_stage u_out (
        .mode_i   (mode_q),
        .pg_in_i  (pg_in_i),
        .pg_out_o (pg_out_o),
        .rst_oe_o (rst_oe_o)
    );

    // Mode register and timer must agree on whether a pulse is running
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert (busy_o == tmr_active)
                else $error("mode and timer disagree");
        end
    end
endmodule

// File: rtl/hrp_checker.sv
// Port-level protocol checker for host_reset_pulser, attached by bind.
module hrp_checker (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic cold_sel_i,
    input logic pg_in_i,
    input logic pg_out_o,
    input logic rst_oe_o,
    input logic busy_o
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy_o && !rst_oe_o)); // R1
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pg_out_o == pg_in_i)); // R2
    AST_COLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rst_oe_o) |-> !pg_out_o); // R10
    AST_COLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o && cold_sel_i && !pg_in_i) |=> !busy_o); // R4
    AST_WARM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_oe_o) |-> $past(req_i && !cold_sel_i && !busy_o)); // R5
    AST_WARM_KEEPS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_oe_o |-> (pg_out_o == pg_in_i)); // R6
    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_oe_o |-> busy_o); // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i)); // R9
endmodule

bind host_reset_pulser hrp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .cold_sel_i (cold_sel_i),
    .pg_in_i    (pg_in_i),
    .pg_out_o   (pg_out_o),
    .rst_oe_o   (rst_oe_o),
    .busy_o     (busy_o)
);

// File: tb/tb_host_reset_pulser.sv
`timescale 1ns/1ps
module tb_host_reset_pulser;
    localparam int CPU   = 2;
    localparam int CUS   = 5;
    localparam int WUS   = 2;
    localparam int COLDN = CPU * CUS;
    localparam int WARMN = CPU * WUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic cold_sel = 1'b0;
    logic pg_in = 1'b0;
    logic pg_out, rst_oe, busy;

    int    n_run = 0;
    int    n_fail = 0;
    string phase = "R1";
    int    m_kind = 0;
    int    m_left = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    host_reset_pulser #(.CLKS_PER_US(CPU), .COLD_US(CUS), .WARM_US(WUS)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cold_sel_i(cold_sel),
        .pg_in_i(pg_in), .pg_out_o(pg_out), .rst_oe_o(rst_oe), .busy_o(busy)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 cold, 2 warm; remaining cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            m_kind = 0;
            m_left = 0;
        end else if (m_kind != 0) begin
            if (m_left == 1) m_kind = 0;
            else m_left--;
        end else if (req) begin
            if (cold_sel && pg_in) begin m_kind = 1; m_left = COLDN; end
            else if (!cold_sel) begin m_kind = 2; m_left = WARMN; end
        end
        #1;
        check(phase, "busy", int'(busy), int'(m_kind != 0));
        check(phase, "rst_oe", int'(rst_oe), int'(m_kind == 2));
        check(phase, "pg_out", int'(pg_out), (m_kind == 1) ? 0 : int'(pg_in));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Directed width measurement of one pulse, counted at the ports
    task automatic measure(input bit cold, input string tag, input int exp);
        int w_busy = 0;
        int w_sig = 0;
        @(negedge clk);
        pg_in = 1'b1; cold_sel = cold; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (busy) begin
            w_busy++;
            if (cold ? !pg_out : rst_oe) w_sig++;
            @(negedge clk);
        end
        check(tag, "busy width", w_busy, exp);
        check(tag, "pulse width", w_sig, exp);
    endtask

    initial begin
        phase = "R1";
        cyc(3);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "oe in reset", int'(rst_oe), 0);
        rst_n = 1'b1;
        cyc(2);
        phase = "R2";
        for (int i = 0; i < 6; i++) begin pg_in = i[0]; cyc(1); end
        phase = "R3";
        pg_in = 1'b1; cold_sel = 1'b1; req = 1'b1; cyc(1); req = 1'b0;
        cyc(3);
        phase = "R10";
        pg_in = 1'b0; cyc(2); pg_in = 1'b1;
        cyc(COLDN);
        phase = "R4";
        pg_in = 1'b0; cold_sel = 1'b1; req = 1'b1; cyc(1); req = 1'b0; cyc(1);
        check("R4", "busy after ignored cold", int'(busy), 0);
        cyc(3);
        phase = "R6";
        pg_in = 1'b1; cold_sel = 1'b0; req = 1'b1; cyc(1); req = 1'b0;
        pg_in = 1'b0; cyc(1); pg_in = 1'b1; cyc(WARMN + 2);
        phase = "R7";
        cold_sel = 1'b1; req = 1'b1; cyc(1); req = 1'b0; cyc(COLDN + 2);
        phase = "R9";
        cold_sel = 1'b0; req = 1'b1; cyc(3 * WARMN + 2); req = 1'b0; cyc(WARMN + 2);
        phase = "R5";
        measure(1'b0, "R5", WARMN);
        phase = "R8";
        measure(1'b1, "R3", COLDN);
        cyc(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule